// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit of a 32-bit RISC core that runs each instruction over several clocks. It spends one clock per step: fetch, decode, execute or address calculation, memory access, and write-back. A small state register records the current step. Every datapath control line is decoded combinationally from that register, so each line changes only at a clock edge.

The block reads two inputs from the datapath. The first is the 6-bit opcode held in the instruction register. The second is the ALU zero flag. It handles five instruction classes, and they take different numbers of clocks:

| Class | Clocks |
|---|---|
| Jump | 3 |
| Branch-if-equal | 3 |
| R-type | 4 |
| Store | 4 |
| Load | 5 |

An opcode outside these classes ends the instruction after decode.

The block also exports the final PC write enable, which is the unconditional PC write ORed with the conditional PC write gated by the zero flag.

None of the pins carries a data stream. The opcode and the zero flag are plain level inputs, and the datapath holds the opcode stable from the end of fetch until the next fetch. Because nothing is streamed, there is no valid/ready handshake and no back-pressure.

Top module: `mcyc_seq_ctrl`

## Requirements

- R1: While `rst` is high at a rising clock edge, the sequencer enters the fetch step. From the first edge onward, its outputs equal the fetch outputs of R2.
- R2: The fetch step drives these outputs and moves to decode on the next clock:
  - `mem_rd`=1, `addr_sel`=0 and `ir_load`=1.
  - `alu_a_sel`=0 and `alu_b_sel`=01. The code 01 selects the constant 4.
  - `alu_mode`=00, which means add.
  - `pc_wr`=1 and `pc_src`=00, which selects the ALU result.
- R3: The decode step drives `alu_a_sel`=0, `alu_b_sel`=11 (shifted offset) and `alu_mode`=00. It then dispatches on `opcode` as follows:
  - 100011 (load) and 101011 (store) go to address calculation.
  - 000000 (R-type) goes to execute.
  - 000100 (branch-if-equal) goes to branch.
  - 000010 (jump) goes to jump.
- R4: The address calculation step drives `alu_a_sel`=1, `alu_b_sel`=10 (sign-extended offset) and `alu_mode`=00. A load then goes to memory read and a store goes to memory write.
- R5: A load runs through five steps: fetch, decode, address calculation, memory read, and write-back.
  - The memory read step drives `mem_rd`=1 and `addr_sel`=1.
  - The write-back step drives `rf_we`=1, `rf_dst_rd`=0 and `wb_from_mem`=1, then returns to fetch.
- R6: A store runs through four steps: fetch, decode, address calculation, and memory write. The memory write step drives `mem_wr`=1 and `addr_sel`=1, then returns to fetch.
- R7: An R-type instruction runs through four steps: fetch, decode, execute, and completion.
  - Execute drives `alu_a_sel`=1, `alu_b_sel`=00 (register B) and `alu_mode`=10 (function field).
  - Completion drives `rf_we`=1, `rf_dst_rd`=1 and `wb_from_mem`=0, then returns to fetch.
- R8: A branch-if-equal runs through three steps. Its last step drives these outputs and then returns to fetch:
  - `alu_a_sel`=1 and `alu_b_sel`=00.
  - `alu_mode`=01, which means subtract.
  - `pc_wr_cond`=1 and `pc_src`=01, which selects the registered ALU result.
- R9: A jump runs through three steps. Its last step drives `pc_wr`=1 and `pc_src`=10 (jump target), then returns to fetch.
- R10: Any other opcode seen in decode sends the sequencer straight back to fetch, so the instruction takes two clocks.
- R11: In every step, each control output not named for that step is 0.
- R12: `pc_en` equals `pc_wr` OR (`pc_wr_cond` AND `alu_zero`), combinationally, in every step.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write when zero is set |
| addr_sel | output | 1 | Memory address source: 0 is the PC, 1 is the ALU output register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_load | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data: 1 is the memory data register, 0 is the ALU output |
| pc_src | output | 2 | PC source select |
| alu_mode | output | 2 | ALU operation class |
| alu_a_sel | output | 1 | ALU A input: 0 is the PC, 1 is register A |
| alu_b_sel | output | 2 | ALU B input select |
| rf_we | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination field: 1 is rd, 0 is rt |
| pc_en | output | 1 | Effective PC write enable |

## Verification

The bench goes after the points where the sequence branches.

- **Decode dispatch.** A swapped or missing opcode match would send a load down the store path, which shows up as `mem_wr` where `mem_rd` was due. It could also make an R-type instruction take the wrong number of clocks.
- **Split after address calculation.** Mixing up load and store there would shorten a load to four clocks or lengthen a store to five.
- **Unknown opcodes.** The bench applies undefined opcodes. A design that fell into some valid path, or stalled, would stretch the two-clock instruction.
- **Zero flag gating.** The bench toggles `alu_zero` in every step. A `pc_en` that ignored the flag during branch, or let it leak into other steps, would cause a mismatch.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

  localparam int OPC_W   = 6;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDRD   = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STWR   = 4'd5,
    ST_EXEC   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BEQ    = 4'd8,
    ST_JMP    = 4'd9
  } state_t;

  typedef enum logic [2:0] {
    CL_RTYPE,
    CL_LOAD,
    CL_STORE,
    CL_BRANCH,
    CL_JUMP,
    CL_BAD
  } op_class_t;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

  localparam logic [1:0] BSEL_REG   = 2'b00;
  localparam logic [1:0] BSEL_FOUR  = 2'b01;
  localparam logic [1:0] BSEL_SEXT  = 2'b10;
  localparam logic [1:0] BSEL_SHIFT = 2'b11;

  localparam logic [1:0] AMODE_ADD  = 2'b00;
  localparam logic [1:0] AMODE_SUB  = 2'b01;
  localparam logic [1:0] AMODE_FUNC = 2'b10;

  localparam logic [1:0] PSRC_ALU  = 2'b00;
  localparam logic [1:0] PSRC_AREG = 2'b01;
  localparam logic [1:0] PSRC_JMP  = 2'b10;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_load;
    logic       wb_from_mem;
    logic [1:0] pc_src;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_we;
    logic       rf_dst_rd;
  } ctrl_t;

endpackage

// File: rtl/mcyc_op_class.sv
module mcyc_op_class
  import mcyc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_class_t        op_class
);

  always_comb begin
    unique case (opcode)
      OPC_RTYPE: op_class = CL_RTYPE;
      OPC_LOAD:  op_class = CL_LOAD;
      OPC_STORE: op_class = CL_STORE;
      OPC_BEQ:   op_class = CL_BRANCH;
      OPC_JUMP:  op_class = CL_JUMP;
      default:   op_class = CL_BAD;
    endcase
  end

endmodule

// File: rtl/mcyc_next_state.sv
module mcyc_next_state
  import mcyc_pkg::*;
(
  input  state_t    cur,
  input  op_class_t op_class,
  output state_t    nxt
);

  always_comb begin
    nxt = ST_FETCH;
    case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (op_class)
          CL_LOAD, CL_STORE: nxt = ST_ADDR;
          CL_RTYPE:          nxt = ST_EXEC;
          CL_BRANCH:         nxt = ST_BEQ;
          CL_JUMP:           nxt = ST_JMP;
          default:           nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (op_class == CL_LOAD) ? ST_LDRD : ST_STWR;
      ST_LDRD:   nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_RWB;
      default:   nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl_decode.sv
module mcyc_ctrl_decode
  import mcyc_pkg::*;
(
  input  state_t cur,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (cur)
      ST_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_load   = 1'b1;
        ctl.alu_b_sel = BSEL_FOUR;
        ctl.alu_mode  = AMODE_ADD;
        ctl.pc_wr     = 1'b1;
        ctl.pc_src    = PSRC_ALU;
      end
      ST_DECODE: begin
        ctl.alu_b_sel = BSEL_SHIFT;
        ctl.alu_mode  = AMODE_ADD;
      end
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_SEXT;
        ctl.alu_mode  = AMODE_ADD;
      end
      ST_LDRD: begin
        ctl.mem_rd   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_LDWB: begin
        ctl.rf_we       = 1'b1;
        ctl.wb_from_mem = 1'b1;
      end
      ST_STWR: begin
        ctl.mem_wr   = 1'b1;
        ctl.addr_sel = 1'b1;
      end
      ST_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_REG;
        ctl.alu_mode  = AMODE_FUNC;
      end
      ST_RWB: begin
        ctl.rf_we     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      ST_BEQ: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = BSEL_REG;
        ctl.alu_mode   = AMODE_SUB;
        ctl.pc_wr_cond = 1'b1;
        ctl.pc_src     = PSRC_AREG;
      end
      ST_JMP: begin
        ctl.pc_wr  = 1'b1;
        ctl.pc_src = PSRC_JMP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_pc_gate.sv
module mcyc_pc_gate (
  input  logic pc_wr,
  input  logic pc_wr_cond,
  input  logic alu_zero,
  output logic pc_en
);

  always_comb pc_en = pc_wr | (pc_wr_cond & alu_zero);

endmodule

// File: rtl/mcyc_seq_ctrl.sv
module mcyc_seq_ctrl
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_zero,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             addr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             ir_load,
  output logic             wb_from_mem,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_mode,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_we,
  output logic             rf_dst_rd,
  output logic             pc_en
);

  state_t    state_q;
  state_t    state_d;
  op_class_t op_class;
  ctrl_t     ctl;

  mcyc_op_class u_class (
    .opcode   (opcode),
    .op_class (op_class)
  );

  mcyc_next_state u_next (
    .cur      (state_q),
    .op_class (op_class),
    .nxt      (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  mcyc_ctrl_decode u_dec (
    .cur (state_q),
    .ctl (ctl)
  );

  assign pc_wr       = ctl.pc_wr;
  assign pc_wr_cond  = ctl.pc_wr_cond;
  assign addr_sel    = ctl.addr_sel;
  assign mem_rd      = ctl.mem_rd;
  assign mem_wr      = ctl.mem_wr;
  assign ir_load     = ctl.ir_load;
  assign wb_from_mem = ctl.wb_from_mem;
  assign pc_src      = ctl.pc_src;
  assign alu_mode    = ctl.alu_mode;
  assign alu_a_sel   = ctl.alu_a_sel;
  assign alu_b_sel   = ctl.alu_b_sel;
  assign rf_we       = ctl.rf_we;
  assign rf_dst_rd   = ctl.rf_dst_rd;

  mcyc_pc_gate u_gate (
    .pc_wr      (ctl.pc_wr),
    .pc_wr_cond (ctl.pc_wr_cond),
    .alu_zero   (alu_zero),
    .pc_en      (pc_en)
  );

  // R2: fetch always hands over to decode
  p_fetch_next_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  // R3: jump opcode in decode lands in the jump step
  p_dispatch_jump_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE && opcode == OPC_JUMP) |=> (state_q == ST_JMP));

  // R5: a load memory read is followed by a register write from memory
  p_load_wb_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel) |=> (rf_we && wb_from_mem));

  // R10: unknown opcode in decode goes back to fetch
  p_bad_op_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DECODE && op_class == CL_BAD) |=> ir_load);

  // R11: at most one of memory read, memory write, register write
  p_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr, rf_we}));

  // R12: enable follows unconditional write and gated conditional write
  p_pcen_on_r12: assert property (@(posedge clk) disable iff (rst)
    (pc_wr || (pc_wr_cond && alu_zero)) |-> pc_en);

  p_pcen_off_r12: assert property (@(posedge clk) disable iff (rst)
    (!pc_wr && !(pc_wr_cond && alu_zero)) |-> !pc_en);

endmodule

// File: tb/sim_mcyc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_mcyc_seq_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       alu_zero = 1'b0;
  logic pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_load, wb_from_mem;
  logic [1:0] pc_src, alu_mode, alu_b_sel;
  logic alu_a_sel, rf_we, rf_dst_rd, pc_en;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  mcyc_seq_ctrl u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_load(ir_load),
    .wb_from_mem(wb_from_mem), .pc_src(pc_src), .alu_mode(alu_mode),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_we(rf_we),
    .rf_dst_rd(rf_dst_rd), .pc_en(pc_en)
  );

  // {pc_wr,pc_wr_cond,addr_sel,mem_rd,mem_wr,ir_load,wb_from_mem,
  //  pc_src[2],alu_mode[2],alu_a_sel,alu_b_sel[2],rf_we,rf_dst_rd}
  function automatic logic [15:0] exp_ctrl(input int st);
    case (st)
      0: return {1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'b00,2'b00,1'b0,2'b01,1'b0,1'b0};
      1: return {7'b0,2'b00,2'b00,1'b0,2'b11,2'b00};
      2: return {7'b0,2'b00,2'b00,1'b1,2'b10,2'b00};
      3: return {1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,2'b00};
      4: return {1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0,2'b00,1'b1,1'b0};
      5: return {1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,2'b00};
      6: return {7'b0,2'b00,2'b10,1'b1,2'b00,2'b00};
      7: return {7'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1};
      8: return {1'b0,1'b1,5'b0,2'b01,2'b01,1'b1,2'b00,2'b00};
      default: return {1'b1,6'b0,2'b10,2'b00,1'b0,2'b00,2'b00};
    endcase
  endfunction

  function automatic int next_st(input int st, input logic [5:0] op);
    case (st)
      0: return 1;
      1: case (op)
           6'b100011, 6'b101011: return 2;
           6'b000000: return 6;
           6'b000100: return 8;
           6'b000010: return 9;
           default:   return 0;
         endcase
      2: return (op == 6'b100011) ? 3 : 5;
      3: return 4;
      6: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_len(input logic [5:0] op);
    case (op)
      6'b100011: return 5;
      6'b101011, 6'b000000: return 4;
      6'b000100, 6'b000010: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string req_of(input int st);
    case (st)
      0: return "R2,R11";
      1: return "R3,R11";
      2: return "R4,R11";
      3, 4: return "R5,R11";
      5: return "R6,R11";
      6, 7: return "R7,R11";
      8: return "R8,R11";
      default: return "R9,R11";
    endcase
  endfunction

  function automatic logic [15:0] act_ctrl();
    return {pc_wr, pc_wr_cond, addr_sel, mem_rd, mem_wr, ir_load, wb_from_mem,
            pc_src, alu_mode, alu_a_sel, alu_b_sel, rf_we, rf_dst_rd};
  endfunction

  task automatic check_vec(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s ctrl act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      finish_run();
    end
  end

  logic [5:0] directed [8] = '{6'b000000, 6'b100011, 6'b101011, 6'b000100,
                               6'b000010, 6'b111111, 6'b000001, 6'b100011};

  initial begin
    int st = 0;
    int len = 0;
    int instr = 0;
    bit seen = 1'b0;
    logic [5:0] cur_op = 6'd0;
    logic [5:0] valid_ops [5] = '{6'b000000, 6'b100011, 6'b101011, 6'b000100, 6'b000010};
    void'($urandom(32'd2024));

    // R1: reset lands in fetch
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check_vec("R1 reset", act_ctrl(), exp_ctrl(0));
    end
    rst = 1'b0;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc != 0) @(negedge clk);
      if (st == 0) begin
        if (instr < 8) opcode = directed[instr];
        else if ($urandom_range(0, 9) < 8) opcode = valid_ops[$urandom_range(0, 4)];
        else opcode = 6'($urandom);
        instr++;
      end
      alu_zero = 1'($urandom);
      #1;
      check_vec(req_of(st), act_ctrl(), exp_ctrl(st));
      check_int("R12 pc_en", int'(pc_en), int'(pc_wr | (pc_wr_cond & alu_zero)));
      if (ir_load) begin
        if (seen)
          check_int((exp_len(cur_op) == 2) ? "R10 length" : "R5,R6,R7,R8,R9 length",
                    len, exp_len(cur_op));
        seen = 1'b1;
        len = 1;
        cur_op = opcode;
      end else begin
        len++;
      end
      st = next_st(st, opcode);
    end
    finish_run();
  end

endmodule